// File: doc/BRIEF.md
# Speculative Path History Buffer

This block records, for a single thread, the indirect branches that have been fetched but may still be thrown away. Each record keeps the branch address, the predicted or resolved target, and a 16-bit sequence number. The front end appends a record when it fetches an indirect branch. The back end advances a commit point as branches retire and cuts off younger records on a misprediction. After a squash, the branch that resolved the misprediction is now the youngest record, and its target can be rewritten with the real destination.

A downstream target predictor folds the targets of the most recent HN records into its set index. The buffer therefore shows those targets newest first, with a thermometer valid mask, and also shows the branch address of the youngest record. Committed records stay in the buffer as hashing context until HN of them have been committed. From then on, each further qualifying commit retires the oldest record.

Storage is a power-of-two ring of DEPTH slots, tracked by a head index, an occupancy count and a commit offset measured from the head. Only one operation takes effect per cycle. A squash is resolved in a single cycle by comparing every slot in parallel.

Top module: `path_hist_buf`

## Requirements
- R1: After reset the buffer is empty: `hist_vld_o` is all zero, `young_pc_o` is zero and `ovf_o` is low.
- R2: A push into a buffer holding fewer than DEPTH records appends a new youngest record. From the next cycle, slot 0 of `hist_tgt_o` (bits AW-1:0) shows its target and `young_pc_o` shows its branch address.
- R3: Slot p of `hist_tgt_o` (bits p*AW+AW-1 : p*AW) holds the target of the p-th youngest record, with p = 0 the youngest. Bit p of `hist_vld_o` is set exactly when at least p+1 records exist, so the mask is a thermometer code from bit 0, capped at HN bits.
- R4: A push while DEPTH records are held is dropped and leaves the contents unchanged. `ovf_o` is high for exactly the cycle after the dropped push.
- R5: A commit has no effect when the buffer is empty. It also has no effect when the record at the commit offset does not exist or carries a sequence number greater than the commit number.
- R6: A qualifying commit advances the commit offset by one while the offset is below HN. Once the offset has reached HN, a qualifying commit removes the oldest record and frees one slot.
- R7: A squash with number S removes the oldest record whose sequence number exceeds S, together with every record younger than it. If no record exceeds S, nothing changes.
- R8: A retarget replaces the target of the youngest record and keeps its branch address, its sequence number and the record count. A retarget of an empty buffer has no effect.
- R9: One operation takes effect per cycle, in this priority: squash, then push, then commit, then retarget. Lower-priority requests in the same cycle are discarded.
- R10: Sequence numbers are compared as unsigned 16-bit values; for example, 16'hFFF0 is greater than 16'h0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_vld_i | input | 1 | Append a record this cycle |
| push_pc_i | input | AW | Branch address of the appended record |
| push_tgt_i | input | AW | Target of the appended record |
| push_seq_i | input | SW | Sequence number of the appended record |
| cmt_vld_i | input | 1 | Commit request |
| cmt_seq_i | input | SW | Commit up-to sequence number |
| sq_vld_i | input | 1 | Squash request |
| sq_seq_i | input | SW | Records with a greater number are discarded |
| rt_vld_i | input | 1 | Retarget the youngest record |
| rt_tgt_i | input | AW | New target for the youngest record |
| hist_tgt_o | output | HN*AW | Targets, youngest in slot 0 |
| hist_vld_o | output | HN | Thermometer mask of valid slots |
| young_pc_o | output | AW | Branch address of the youngest record, zero if empty |
| ovf_o | output | 1 | High the cycle after a push was dropped |

## Verification
The squash property only holds because the cut point is the first record, counted from the oldest, whose number exceeds S. Every record before the cut therefore satisfies the bound, whatever the order in which sequence numbers were pushed. The priority and retarget properties assume that all request lines are plain levels sampled once per edge. The bench drives them at the falling edge and clears them before the next one. Pushes in the bench use ascending sequence numbers, except in the deliberate wrap-style case that exercises the unsigned compare. Coincident requests appear only in the priority scenario.

// File: rtl/phb_pkg.sv
// Package for the path history buffer: operation encoding and the
// per-cycle arbitration that picks exactly one operation.
package phb_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SQUASH,
        OP_PUSH,
        OP_COMMIT,
        OP_RETGT
    } phb_op_e;

    // Fixed priority: squash, push, commit, retarget.
    function automatic phb_op_e pick_op(input logic sq, input logic pu,
                                        input logic cm, input logic rt);
        phb_op_e op;
        if (sq)      op = OP_SQUASH;
        else if (pu) op = OP_PUSH;
        else if (cm) op = OP_COMMIT;
        else if (rt) op = OP_RETGT;
        else         op = OP_NONE;
        return op;
    endfunction

endpackage

// File: rtl/phb_store.sv
// Slot storage of the ring. Each slot holds branch address, target and
// sequence number. Assumes the controller never asserts push-write and
// retarget-write in the same cycle (the arbiter grants one operation).
module phb_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int SW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_pc,
    input  logic [AW-1:0] wr_tgt,
    input  logic [SW-1:0] wr_seq,
    input  logic          rt_en,
    input  logic [PW-1:0] rt_idx,
    input  logic [AW-1:0] rt_tgt,
    output logic [AW-1:0] pc_q  [DEPTH],
    output logic [AW-1:0] tgt_q [DEPTH],
    output logic [SW-1:0] seq_q [DEPTH]
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot register: loaded by a push, target rewritten by a retarget.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[s]  <= '0;
                tgt_q[s] <= '0;
                seq_q[s] <= '0;
            end else if (wr_en && wr_idx == PW'(s)) begin
                pc_q[s]  <= wr_pc;
                tgt_q[s] <= wr_tgt;
                seq_q[s] <= wr_seq;
            end else if (rt_en && rt_idx == PW'(s)) begin
                tgt_q[s] <= rt_tgt;
            end
        end
    end

endmodule

// File: rtl/phb_cut_find.sv
// Parallel squash search: finds the offset (from the head) of the oldest
// live record whose sequence number is above the squash number.
// Assumes DEPTH is a power of two so the ring index wraps by truncation.
module phb_cut_find #(
    parameter int DEPTH = 16,
    parameter int SW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [SW-1:0] seq_q [DEPTH],
    input  logic [PW-1:0] head,
    input  logic [CW-1:0] count,
    input  logic [SW-1:0] sq_seq,
    output logic          found,
    output logic [CW-1:0] cut_cnt
);

    logic [DEPTH-1:0] younger;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        logic [PW-1:0] idx;
        assign idx        = head + PW'(k);
        assign younger[k] = (CW'(k) < count) && (seq_q[idx] > sq_seq);
    end

    // Priority encoder: lowest offset wins, i.e. the oldest such record.
    always_comb begin
        found   = 1'b0;
        cut_cnt = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (younger[k]) begin
                found   = 1'b1;
                cut_cnt = CW'(k);
            end
        end
    end

endmodule

// File: rtl/phb_ctrl.sv
// Ring control: arbitrates one operation per cycle and keeps the head
// index, occupancy count, commit offset and overflow flag. The commit
// offset counts from the head, so retiring the oldest record keeps it.
module phb_ctrl
    import phb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int HN    = 4,
    parameter int SW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_vld,
    input  logic          cmt_vld,
    input  logic [SW-1:0] cmt_seq,
    input  logic          sq_vld,
    input  logic          rt_vld,
    input  logic [SW-1:0] seq_q [DEPTH],
    input  logic          cut_found,
    input  logic [CW-1:0] cut_cnt,
    output logic [PW-1:0] head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] cptr,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic          rt_en,
    output logic [PW-1:0] rt_idx,
    output logic          ovf
);

    phb_op_e       op;
    logic          full;
    logic [PW-1:0] cmt_idx;
    logic          cmt_act;
    logic          retire;

    // Operation selection and the write strobes towards the slot storage.
    always_comb begin
        op      = pick_op(sq_vld, push_vld, cmt_vld, rt_vld);
        full    = (count == CW'(DEPTH));
        wr_idx  = head + count[PW-1:0];
        rt_idx  = head + count[PW-1:0] - PW'(1);
        cmt_idx = head + cptr[PW-1:0];
        wr_en   = (op == OP_PUSH) && !full;
        rt_en   = (op == OP_RETGT) && (count != '0);
        cmt_act = (op == OP_COMMIT) && (count != '0) && (cptr < count)
                  && (seq_q[cmt_idx] <= cmt_seq);
        retire  = cmt_act && (cptr >= CW'(HN));
    end

    // Pointer, occupancy, commit offset and overflow state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
            cptr  <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= (op == OP_PUSH) && full;
            if (op == OP_SQUASH && cut_found) begin
                count <= cut_cnt;
            end else if (wr_en) begin
                count <= count + CW'(1);
            end else if (retire) begin
                head  <= head + PW'(1);
                count <= count - CW'(1);
            end else if (cmt_act) begin
                cptr  <= cptr + CW'(1);
            end
        end
    end

endmodule

// File: rtl/phb_view.sv
// Read-out for the hashing consumer: the youngest HN targets, youngest
// first, a thermometer valid mask and the youngest branch address.
// Assumes HN <= DEPTH.
module phb_view #(
    parameter int DEPTH = 16,
    parameter int HN    = 4,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]    pc_q  [DEPTH],
    input  logic [AW-1:0]    tgt_q [DEPTH],
    input  logic [PW-1:0]    head,
    input  logic [CW-1:0]    count,
    output logic [HN*AW-1:0] hist_tgt,
    output logic [HN-1:0]    hist_vld,
    output logic [AW-1:0]    young_pc
);

    logic [PW-1:0] young_idx;

    // Youngest slot index and its branch address.
    always_comb begin
        young_idx = head + count[PW-1:0] - PW'(1);
        young_pc  = (count != '0) ? pc_q[young_idx] : '0;
    end

    for (genvar p = 0; p < HN; p++) begin : g_tap
        logic [PW-1:0] idx;
        assign idx         = young_idx - PW'(p);
        assign hist_vld[p] = (CW'(p) < count);
        assign hist_tgt[p*AW +: AW] = hist_vld[p] ? tgt_q[idx] : '0;
    end

endmodule

// File: rtl/path_hist_buf.sv
// Top of the speculative path history buffer for one thread. Joins the
// slot storage, the squash search, the control and the read-out.
// Assumes DEPTH is a power of two and 1 <= HN <= DEPTH.
module path_hist_buf #(
    parameter int DEPTH = 16,
    parameter int HN    = 4,
    parameter int AW    = 32,
    parameter int SW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_vld_i,
    input  logic [AW-1:0]    push_pc_i,
    input  logic [AW-1:0]    push_tgt_i,
    input  logic [SW-1:0]    push_seq_i,
    input  logic             cmt_vld_i,
    input  logic [SW-1:0]    cmt_seq_i,
    input  logic             sq_vld_i,
    input  logic [SW-1:0]    sq_seq_i,
    input  logic             rt_vld_i,
    input  logic [AW-1:0]    rt_tgt_i,
    output logic [HN*AW-1:0] hist_tgt_o,
    output logic [HN-1:0]    hist_vld_o,
    output logic [AW-1:0]    young_pc_o,
    output logic             ovf_o
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] pc_q  [DEPTH];
    logic [AW-1:0] tgt_q [DEPTH];
    logic [SW-1:0] seq_q [DEPTH];
    logic [PW-1:0] head_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] cptr_q;
    logic          wr_en, rt_en, cut_found;
    logic [PW-1:0] wr_idx, rt_idx;
    logic [CW-1:0] cut_cnt;

    phb_store #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_pc  (push_pc_i),
        .wr_tgt (push_tgt_i),
        .wr_seq (push_seq_i),
        .rt_en  (rt_en),
        .rt_idx (rt_idx),
        .rt_tgt (rt_tgt_i),
        .pc_q   (pc_q),
        .tgt_q  (tgt_q),
        .seq_q  (seq_q)
    );

    phb_cut_find #(.DEPTH(DEPTH), .SW(SW)) u_cut (
        .seq_q   (seq_q),
        .head    (head_q),
        .count   (count_q),
        .sq_seq  (sq_seq_i),
        .found   (cut_found),
        .cut_cnt (cut_cnt)
    );

    phb_ctrl #(.DEPTH(DEPTH), .HN(HN), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_vld  (push_vld_i),
        .cmt_vld   (cmt_vld_i),
        .cmt_seq   (cmt_seq_i),
        .sq_vld    (sq_vld_i),
        .rt_vld    (rt_vld_i),
        .seq_q     (seq_q),
        .cut_found (cut_found),
        .cut_cnt   (cut_cnt),
        .head      (head_q),
        .count     (count_q),
        .cptr      (cptr_q),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rt_en     (rt_en),
        .rt_idx    (rt_idx),
        .ovf       (ovf_o)
    );

    phb_view #(.DEPTH(DEPTH), .HN(HN), .AW(AW)) u_view (
        .pc_q     (pc_q),
        .tgt_q    (tgt_q),
        .head     (head_q),
        .count    (count_q),
        .hist_tgt (hist_tgt_o),
        .hist_vld (hist_vld_o),
        .young_pc (young_pc_o)
    );

endmodule

// File: rtl/phb_chk.sv
// Property checker for path_hist_buf, attached by the bind below.
// Relates request ports to occupancy, commit offset and outputs.
module phb_chk #(
    parameter int DEPTH = 16,
    parameter int HN    = 4,
    parameter int AW    = 32,
    parameter int SW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_vld_i,
    input logic [AW-1:0]    push_tgt_i,
    input logic             cmt_vld_i,
    input logic             sq_vld_i,
    input logic [SW-1:0]    sq_seq_i,
    input logic             rt_vld_i,
    input logic [HN*AW-1:0] hist_tgt_o,
    input logic [HN-1:0]    hist_vld_o,
    input logic             ovf_o,
    input logic [PW-1:0]    head_q,
    input logic [CW-1:0]    count_q,
    input logic [CW-1:0]    cptr_q,
    input logic [SW-1:0]    seq_q [DEPTH]
);

    logic [PW-1:0] yidx;
    logic [SW-1:0] young_seq;
    assign yidx      = head_q + count_q[PW-1:0] - PW'(1);
    assign young_seq = seq_q[yidx];

    // R2
    push_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld_i && !sq_vld_i && count_q < CW'(DEPTH)) |=>
        (count_q == $past(count_q) + CW'(1)) && (hist_tgt_o[AW-1:0] == $past(push_tgt_i)));

    // R3
    mask_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_vld_o & (hist_vld_o + HN'(1))) == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(push_vld_i && !sq_vld_i && count_q == CW'(DEPTH)));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R6
    cptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cptr_q <= CW'(HN));

    // R7
    sq_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_vld_i |=> (count_q == '0) || (young_seq <= $past(sq_seq_i)));

    // R8
    retgt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_vld_i && !sq_vld_i && !push_vld_i && !cmt_vld_i) |=> $stable(count_q));

    // R9
    sq_over_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_vld_i && push_vld_i) |=> !ovf_o && (count_q <= $past(count_q)));

endmodule

bind path_hist_buf phb_chk #(.DEPTH(DEPTH), .HN(HN), .AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_vld_i (push_vld_i),
    .push_tgt_i (push_tgt_i),
    .cmt_vld_i  (cmt_vld_i),
    .sq_vld_i   (sq_vld_i),
    .sq_seq_i   (sq_seq_i),
    .rt_vld_i   (rt_vld_i),
    .hist_tgt_o (hist_tgt_o),
    .hist_vld_o (hist_vld_o),
    .ovf_o      (ovf_o),
    .head_q     (head_q),
    .count_q    (count_q),
    .cptr_q     (cptr_q),
    .seq_q      (seq_q)
);

// File: tb/path_hist_buf_bench.sv
`timescale 1ns/1ps
// Directed bench for path_hist_buf: one task per scenario.
module path_hist_buf_bench;

    localparam int DEPTH = 16;
    localparam int HN    = 4;
    localparam int AW    = 32;
    localparam int SW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_vld_i = 1'b0, cmt_vld_i = 1'b0, sq_vld_i = 1'b0, rt_vld_i = 1'b0;
    logic [AW-1:0]    push_pc_i = '0, push_tgt_i = '0, rt_tgt_i = '0;
    logic [SW-1:0]    push_seq_i = '0, cmt_seq_i = '0, sq_seq_i = '0;
    logic [HN*AW-1:0] hist_tgt_o;
    logic [HN-1:0]    hist_vld_o;
    logic [AW-1:0]    young_pc_o;
    logic             ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    path_hist_buf #(.DEPTH(DEPTH), .HN(HN), .AW(AW), .SW(SW)) u_path_hist_buf (
        .clk(clk), .rst_n(rst_n),
        .push_vld_i(push_vld_i), .push_pc_i(push_pc_i), .push_tgt_i(push_tgt_i),
        .push_seq_i(push_seq_i), .cmt_vld_i(cmt_vld_i), .cmt_seq_i(cmt_seq_i),
        .sq_vld_i(sq_vld_i), .sq_seq_i(sq_seq_i), .rt_vld_i(rt_vld_i),
        .rt_tgt_i(rt_tgt_i), .hist_tgt_o(hist_tgt_o), .hist_vld_o(hist_vld_o),
        .young_pc_o(young_pc_o), .ovf_o(ovf_o)
    );

    function automatic logic [AW-1:0] tg(input int i);
        return 32'hA000_0000 | AW'(i);
    endfunction

    function automatic logic [AW-1:0] pcv(input int i);
        return 32'h1000_0000 | AW'(i);
    endfunction

    function automatic logic [AW-1:0] slot(input int p);
        return hist_tgt_o[p*AW +: AW];
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Apply the requests set by the caller for one cycle, then clear them.
    task automatic step();
        @(negedge clk);
        push_vld_i = 1'b0; cmt_vld_i = 1'b0; sq_vld_i = 1'b0; rt_vld_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input int i, input logic [SW-1:0] s);
        push_vld_i = 1'b1; push_pc_i = pcv(i); push_tgt_i = tg(i); push_seq_i = s;
        step();
    endtask

    task automatic commit(input logic [SW-1:0] s);
        cmt_vld_i = 1'b1; cmt_seq_i = s;
        step();
    endtask

    task automatic squash(input logic [SW-1:0] s);
        sq_vld_i = 1'b1; sq_seq_i = s;
        step();
    endtask

    task automatic retgt(input logic [AW-1:0] t);
        rt_vld_i = 1'b1; rt_tgt_i = t;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 vld", 64'(hist_vld_o), 64'h0);
        chk("R1 ovf", 64'(ovf_o), 64'h0);
        chk("R1 pc", 64'(young_pc_o), 64'h0);
        retgt(32'hDEAD_0000);
        chk("R8 empty retarget vld", 64'(hist_vld_o), 64'h0);
    endtask

    task automatic t_push_order();
        do_reset();
        push(1, 16'd10);
        push(2, 16'd20);
        chk("R3 mask two", 64'(hist_vld_o), 64'h3);
        chk("R2 slot0", 64'(slot(0)), 64'(tg(2)));
        chk("R3 slot1", 64'(slot(1)), 64'(tg(1)));
        for (int i = 3; i <= 5; i++) push(i, SW'(i * 10));
        chk("R3 mask capped", 64'(hist_vld_o), 64'hF);
        for (int p = 0; p < HN; p++) chk("R3 order", 64'(slot(p)), 64'(tg(5 - p)));
        chk("R2 young pc", 64'(young_pc_o), 64'(pcv(5)));
        retgt(32'h0000_BEEF);
        chk("R8 new target", 64'(slot(0)), 64'h0000_BEEF);
        chk("R8 older kept", 64'(slot(1)), 64'(tg(4)));
        chk("R8 pc kept", 64'(young_pc_o), 64'(pcv(5)));
        chk("R8 count kept", 64'(hist_vld_o), 64'hF);
    endtask

    task automatic t_squash();
        do_reset();
        for (int i = 1; i <= 5; i++) push(i, SW'(i * 10));
        squash(16'd100);
        chk("R7 none younger vld", 64'(hist_vld_o), 64'hF);
        chk("R7 none younger slot0", 64'(slot(0)), 64'(tg(5)));
        squash(16'd25);
        chk("R7 cut vld", 64'(hist_vld_o), 64'h3);
        chk("R7 cut slot0", 64'(slot(0)), 64'(tg(2)));
        chk("R7 cut slot1", 64'(slot(1)), 64'(tg(1)));
        squash(16'd5);
        chk("R7 cut all", 64'(hist_vld_o), 64'h0);
        push(7, 16'h0008);
        push(8, 16'hFFF0);
        squash(16'h0010);
        chk("R10 unsigned vld", 64'(hist_vld_o), 64'h1);
        chk("R10 unsigned slot0", 64'(slot(0)), 64'(tg(7)));
    endtask

    task automatic t_full_commit();
        do_reset();
        for (int i = 1; i <= DEPTH; i++) push(i, SW'(i));
        chk("R4 no ovf at full", 64'(ovf_o), 64'h0);
        push(99, 16'd99);
        chk("R4 ovf pulse", 64'(ovf_o), 64'h1);
        chk("R4 dropped", 64'(slot(0)), 64'(tg(DEPTH)));
        step();
        chk("R4 ovf one cycle", 64'(ovf_o), 64'h0);
        commit(16'd0);
        for (int k = 0; k < HN; k++) commit(16'd100);
        push(98, 16'd98);
        chk("R5 R6 retained, still full", 64'(ovf_o), 64'h1);
        commit(16'd100);
        push(97, 16'd97);
        chk("R6 retire frees slot", 64'(ovf_o), 64'h0);
        chk("R6 new youngest", 64'(slot(0)), 64'(tg(97)));
    endtask

    task automatic t_priority();
        do_reset();
        push(1, 16'd10);
        push(2, 16'd20);
        sq_vld_i = 1'b1; sq_seq_i = 16'd15;
        push_vld_i = 1'b1; push_pc_i = pcv(3); push_tgt_i = tg(3); push_seq_i = 16'd30;
        step();
        chk("R9 squash wins vld", 64'(hist_vld_o), 64'h1);
        chk("R9 squash wins slot0", 64'(slot(0)), 64'(tg(1)));
        push_vld_i = 1'b1; push_pc_i = pcv(4); push_tgt_i = tg(4); push_seq_i = 16'd40;
        rt_vld_i = 1'b1; rt_tgt_i = 32'h0000_0E0E;
        step();
        chk("R9 push over retarget slot0", 64'(slot(0)), 64'(tg(4)));
        chk("R9 push over retarget slot1", 64'(slot(1)), 64'(tg(1)));
        cmt_vld_i = 1'b1; cmt_seq_i = 16'd100;
        rt_vld_i = 1'b1; rt_tgt_i = 32'h0000_0F0F;
        step();
        chk("R9 commit over retarget", 64'(slot(0)), 64'(tg(4)));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_push_order();
        t_squash();
        t_full_commit();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule